// File: doc/BRIEF.md
# Pin Function and Output Latch Controller

This block controls a bank of general-purpose pins through a 32-bit register bus. Each pin owns a 3-bit function code, and that code is packed ten to a word. The code makes the pin an input, a driven output, or hands the pin to one of six alternate peripherals. Every pin's code is forwarded unchanged to an external pad mux. An output enable is asserted only for pins coded as outputs.

Output levels live in a per-pin latch. Software changes that latch only through strobe words, never by a read-modify-write:
- A 1 written to a bit of a set word drives the matching pin high.
- A 1 written to a bit of a clear word drives it low.
- A 0 bit in either word does nothing.

Pin inputs cross into the clock domain through a two-flop synchronizer. They are read back through two read-only level words. Reads are answered one cycle after the request, with a valid strobe.

Top module: `gpio_func_ctrl`

## Requirements
- R1: Pin p's function code is stored at word p/10 (byte offset 4*(p/10), words at 0x00..0x14), bits 3*(p%10)+2 : 3*(p%10). Reading a function word returns the stored codes. Bits 31:30 of every function word read as zero.
- R2: `pin_alt_sel[3p+2:3p]` equals pin p's stored function code, from the cycle after the write. The codes are: input 000, output 001, first to sixth alternates 100, 101, 110, 111, 011, 010.
- R3: `pin_oe[p]` is 1 exactly when pin p's code is 001, from the cycle after the write.
- R4: A write to a set word (0x1C for pins 0..31, 0x20 for pins 32..53) makes `pin_out[p]` 1 in the next cycle for every bit (p%32) written as 1. Pins whose bit is 0 keep their level.
- R5: A write to a clear word (0x28 for pins 0..31, 0x2C for pins 32..53) makes `pin_out[p]` 0 in the next cycle for every bit written as 1. Pins whose bit is 0 keep their level.
- R6: The output latch keeps its value when no set or clear word is written, whatever the pin's function code, including input mode.
- R7: A read of a level word (0x34 for pins 0..31, 0x38 for pins 32..53) returns in bit (p%32) the value `pin_in[p]` had two clock edges before the read request edge. The read data and `bus_rd_valid` appear in the cycle after the request. `bus_rd_data` holds between reads.
- R8: The following all read as zero:
  - set and clear words;
  - unmapped word addresses;
  - addresses whose two low bits are not zero.

  Writes to level words, to unmapped addresses and to misaligned addresses change no state.
- R9: Bits for pins above 53 (bits 31:22 of the second set, clear and level words; bits 31:12 of function word 5) are ignored on write and read as zero.
- R10: A synchronous active-high reset clears all function codes, output latches, synchronizer stages, `bus_rd_data` and `bus_rd_valid`. Every pin then starts as an input driving low.
- R11: A read and a write in the same cycle return the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr_en | input | 1 | Write request |
| bus_rd_en | input | 1 | Read request |
| bus_addr | input | 8 | Byte address |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Read data, registered |
| bus_rd_valid | output | 1 | Read data valid, one cycle after the request |
| pin_in | input | 54 | Raw pin input levels |
| pin_out | output | 54 | Output latch levels |
| pin_oe | output | 54 | Per-pin output enable |
| pin_alt_sel | output | 162 | Per-pin function code, 3 bits per pin |

## Verification
A function code stored in the wrong field shows up on `pin_alt_sel` and `pin_oe` one cycle after the write. It is then visible on every later cycle, so comparing every clock catches it at once. A lost or stray update of an output latch appears on `pin_out` in the next cycle and persists until that pin is next written. A wrong synchronizer depth or a wrong level bit only shows on the level read data, so the stimulus reads those words often while `pin_in` moves.

// File: rtl/gpio_fc_pkg.sv
package gpio_fc_pkg;
  localparam int FUNC_W = 3;

  typedef enum logic [FUNC_W-1:0] {
    FN_INPUT  = 3'b000,
    FN_OUTPUT = 3'b001,
    FN_ALT0   = 3'b100,
    FN_ALT1   = 3'b101,
    FN_ALT2   = 3'b110,
    FN_ALT3   = 3'b111,
    FN_ALT4   = 3'b011,
    FN_ALT5   = 3'b010
  } func_code_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/gpio_fc_fsel_bank.sv
module gpio_fc_fsel_bank
  import gpio_fc_pkg::*;
#(
  parameter int NUM_PINS   = 54,
  parameter int DATA_W     = 32,
  parameter int FSEL_WORDS = 6,
  localparam int PPW       = DATA_W / FUNC_W,
  localparam int FIELD_SPAN = PPW * FUNC_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [FSEL_WORDS-1:0]        wr_sel,
  input  logic [FIELD_SPAN-1:0]        wr_data,
  output logic [NUM_PINS*FUNC_W-1:0]   fsel_flat,
  output logic [NUM_PINS-1:0]          oe,
  output logic [FSEL_WORDS*DATA_W-1:0] rd_words
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int WRD = p / PPW;
    localparam int OFF = FUNC_W * (p % PPW);
    logic [FUNC_W-1:0] code_q;
    logic              oe_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        code_q <= '0;
        oe_q   <= 1'b0;
      end else if (wr_sel[WRD]) begin
        code_q <= wr_data[OFF +: FUNC_W];
        oe_q   <= (wr_data[OFF +: FUNC_W] == FN_OUTPUT);
      end
    end

    assign fsel_flat[p*FUNC_W +: FUNC_W] = code_q;
    assign oe[p] = oe_q;

    AST_OE_ONLY_OUTPUT: assert property (@(posedge clk) disable iff (rst)
      oe[p] |-> (fsel_flat[p*FUNC_W +: FUNC_W] == FN_OUTPUT)); // R3
    AST_CODE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
      wr_sel[WRD] |=> (fsel_flat[p*FUNC_W +: FUNC_W] == $past(wr_data[OFF +: FUNC_W]))); // R2
  end

  always_comb begin
    rd_words = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      rd_words[(p / PPW) * DATA_W + FUNC_W * (p % PPW) +: FUNC_W] = fsel_flat[p*FUNC_W +: FUNC_W];
    end
  end

endmodule

// File: rtl/gpio_fc_out_latch.sv
module gpio_fc_out_latch #(
  parameter int NUM_PINS   = 54,
  parameter int DATA_W     = 32,
  parameter int BANK_WORDS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [BANK_WORDS-1:0] set_sel,
  input  logic [BANK_WORDS-1:0] clr_sel,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [NUM_PINS-1:0]   pin_out
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int WRD = p / DATA_W;
    localparam int BIT = p % DATA_W;
    logic lvl_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q <= 1'b0;
      end else if (set_sel[WRD] && wr_data[BIT]) begin
        lvl_q <= 1'b1;
      end else if (clr_sel[WRD] && wr_data[BIT]) begin
        lvl_q <= 1'b0;
      end
    end

    assign pin_out[p] = lvl_q;

    AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (rst)
      (set_sel[WRD] && wr_data[BIT]) |=> pin_out[p]); // R4
    AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
      (clr_sel[WRD] && wr_data[BIT] && !set_sel[WRD]) |=> !pin_out[p]); // R5
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (set_sel == '0 && clr_sel == '0) |=> $stable(pin_out)); // R6

endmodule

// File: rtl/gpio_fc_in_sync.sv
module gpio_fc_in_sync #(
  parameter int NUM_PINS = 54,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] raw_in,
  output logic [NUM_PINS-1:0] sync_out
);

  logic [NUM_PINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= raw_in;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_func_ctrl.sv
module gpio_func_ctrl
  import gpio_fc_pkg::*;
#(
  parameter int NUM_PINS  = 54,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int SYNC_STG  = 2,
  parameter int FSEL_BASE = 'h00,
  parameter int SET_BASE  = 'h1C,
  parameter int CLR_BASE  = 'h28,
  parameter int LVL_BASE  = 'h34
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr_en,
  input  logic                       bus_rd_en,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wr_data,
  output logic [DATA_W-1:0]          bus_rd_data,
  output logic                       bus_rd_valid,
  input  logic [NUM_PINS-1:0]        pin_in,
  output logic [NUM_PINS-1:0]        pin_out,
  output logic [NUM_PINS-1:0]        pin_oe,
  output logic [NUM_PINS*FUNC_W-1:0] pin_alt_sel
);

  localparam int PPW        = DATA_W / FUNC_W;
  localparam int FSEL_WORDS = ceil_div(NUM_PINS, PPW);
  localparam int BANK_WORDS = ceil_div(NUM_PINS, DATA_W);
  localparam int WORD_AW    = ADDR_W - 2;
  localparam int LVL_PAD    = BANK_WORDS * DATA_W;

  logic [WORD_AW-1:0]          widx;
  logic                        aligned;
  logic [FSEL_WORDS-1:0]       fsel_wsel;
  logic [FSEL_WORDS-1:0]       fsel_hit;
  logic [BANK_WORDS-1:0]       set_wsel;
  logic [BANK_WORDS-1:0]       clr_wsel;
  logic [BANK_WORDS-1:0]       lvl_hit;
  logic [FSEL_WORDS*DATA_W-1:0] fsel_words;
  logic [NUM_PINS-1:0]         lvl_sync;
  logic [LVL_PAD-1:0]          lvl_padded;
  logic [DATA_W-1:0]           rd_mux;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  for (genvar w = 0; w < FSEL_WORDS; w++) begin : g_fsel_dec
    assign fsel_hit[w]  = aligned && (widx == WORD_AW'(FSEL_BASE / 4 + w));
    assign fsel_wsel[w] = bus_wr_en && fsel_hit[w];
  end

  for (genvar w = 0; w < BANK_WORDS; w++) begin : g_bank_dec
    assign set_wsel[w] = bus_wr_en && aligned && (widx == WORD_AW'(SET_BASE / 4 + w));
    assign clr_wsel[w] = bus_wr_en && aligned && (widx == WORD_AW'(CLR_BASE / 4 + w));
    assign lvl_hit[w]  = aligned && (widx == WORD_AW'(LVL_BASE / 4 + w));
  end

  gpio_fc_fsel_bank #(
    .NUM_PINS  (NUM_PINS),
    .DATA_W    (DATA_W),
    .FSEL_WORDS(FSEL_WORDS)
  ) u_fsel (
    .clk      (clk),
    .rst      (rst),
    .wr_sel   (fsel_wsel),
    .wr_data  (bus_wr_data[PPW*FUNC_W-1:0]),
    .fsel_flat(pin_alt_sel),
    .oe       (pin_oe),
    .rd_words (fsel_words)
  );

  gpio_fc_out_latch #(
    .NUM_PINS  (NUM_PINS),
    .DATA_W    (DATA_W),
    .BANK_WORDS(BANK_WORDS)
  ) u_out (
    .clk    (clk),
    .rst    (rst),
    .set_sel(set_wsel),
    .clr_sel(clr_wsel),
    .wr_data(bus_wr_data),
    .pin_out(pin_out)
  );

  gpio_fc_in_sync #(
    .NUM_PINS(NUM_PINS),
    .STAGES  (SYNC_STG)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .raw_in  (pin_in),
    .sync_out(lvl_sync)
  );

  assign lvl_padded = LVL_PAD'(lvl_sync);

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < FSEL_WORDS; w++) begin
      if (fsel_hit[w]) rd_mux = fsel_words[w*DATA_W +: DATA_W];
    end
    for (int w = 0; w < BANK_WORDS; w++) begin
      if (lvl_hit[w]) rd_mux = lvl_padded[w*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rd_data  <= '0;
      bus_rd_valid <= 1'b0;
    end else begin
      bus_rd_valid <= bus_rd_en;
      if (bus_rd_en) bus_rd_data <= rd_mux;
    end
  end

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    bus_rd_valid |-> $past(bus_rd_en)); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> $stable(bus_rd_data)); // R7
  AST_STROBE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && aligned && (widx == WORD_AW'(SET_BASE / 4) || widx == WORD_AW'(CLR_BASE / 4)))
      |=> (bus_rd_data == '0)); // R8
  AST_HIGH_LEVEL_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && lvl_hit[BANK_WORDS-1])
      |=> (bus_rd_data[DATA_W-1:NUM_PINS-(BANK_WORDS-1)*DATA_W] == '0)); // R9

endmodule

// File: tb/gpio_func_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_func_ctrl_bench;
  localparam int NP = 54;

  logic          clk = 1'b0;
  logic          rst;
  logic          bus_wr_en, bus_rd_en;
  logic [7:0]    bus_addr;
  logic [31:0]   bus_wr_data;
  logic [31:0]   bus_rd_data;
  logic          bus_rd_valid;
  logic [NP-1:0] pin_in, pin_out, pin_oe;
  logic [NP*3-1:0] pin_alt_sel;

  always #2.5 clk = ~clk;

  gpio_func_ctrl u_gpio_func_ctrl (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data),
    .bus_rd_valid(bus_rd_valid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_alt_sel(pin_alt_sel)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural reference state
  int            code_m [NP];
  bit            out_m  [NP];
  bit [NP-1:0]   hist [$];
  logic [31:0]   exp_rd;
  bit            exp_vld;
  string         rd_tag = "R10";
  string         out_tag = "R10";

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] r = '0;
    int w;
    bit [NP-1:0] lv;
    if (a[1:0] != 2'b00) return '0;
    w = a >> 2;
    lv = hist[hist.size()-2];
    if (w < 6) begin
      for (int p = 10*w; p < 10*w+10 && p < NP; p++) r[3*(p%10) +: 3] = 3'(code_m[p]);
    end else if (w == 13 || w == 14) begin
      for (int b = 0; b < 32; b++) if (32*(w-13)+b < NP) r[b] = lv[32*(w-13)+b];
    end
    return r;
  endfunction

  function automatic string tag_for(input logic [7:0] a);
    int w = a >> 2;
    if (a[1:0] != 0) return "R8";
    if (w == 5 || w == 14) return "R9";
    if (w < 6) return "R1";
    if (w == 13) return "R7";
    return "R8";
  endfunction

  task automatic cycle(input bit r, input bit we, input bit re, input logic [7:0] a,
                       input logic [31:0] d, input logic [NP-1:0] pi);
    logic [NP*3-1:0] e_alt;
    logic [NP-1:0]   e_oe, e_out;
    int w;
    @(negedge clk);
    rst = r; bus_wr_en = we; bus_rd_en = re; bus_addr = a; bus_wr_data = d; pin_in = pi;
    @(posedge clk);
    if (r) begin
      foreach (code_m[p]) begin code_m[p] = 0; out_m[p] = 0; end
      hist.delete(); hist.push_back('0); hist.push_back('0);
      exp_rd = '0; exp_vld = 0; rd_tag = "R10"; out_tag = "R10";
    end else begin
      exp_vld = re;
      if (re) begin exp_rd = model_read(a); rd_tag = (we ? "R11" : tag_for(a)); end
      if (we && a[1:0] == 0) begin
        w = a >> 2;
        if (w < 6)
          for (int p = 10*w; p < 10*w+10 && p < NP; p++) code_m[p] = int'((d >> (3*(p%10))) & 7);
        if (w == 7 || w == 8) begin
          for (int b = 0; b < 32; b++) if (d[b] && 32*(w-7)+b < NP) out_m[32*(w-7)+b] = 1;
          out_tag = "R4";
        end
        if (w == 10 || w == 11) begin
          for (int b = 0; b < 32; b++) if (d[b] && 32*(w-10)+b < NP) out_m[32*(w-10)+b] = 0;
          out_tag = "R5";
        end
      end else if (!we) out_tag = "R6";
      hist.push_back(pi);
      if (hist.size() > 4) void'(hist.pop_front());
    end
    #1;
    for (int p = 0; p < NP; p++) begin
      e_alt[3*p +: 3] = 3'(code_m[p]);
      e_oe[p]  = (code_m[p] == 1);
      e_out[p] = out_m[p];
    end
    chk(r ? "R10" : "R2", 256'(pin_alt_sel), 256'(e_alt));
    chk(r ? "R10" : "R3", 256'(pin_oe), 256'(e_oe));
    chk(out_tag, 256'(pin_out), 256'(e_out));
    chk(r ? "R10" : "R7", 256'(bus_rd_valid), 256'(exp_vld));
    chk(rd_tag, 256'(bus_rd_data), 256'(exp_rd));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [NP-1:0] pi);
    cycle(0, 1, 0, a, d, pi);
  endtask
  task automatic rd(input logic [7:0] a, input logic [NP-1:0] pi);
    cycle(0, 0, 1, a, 32'h0, pi);
  endtask

  initial begin
    logic [NP-1:0] pv = '0;
    logic [7:0] addrs [16] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h1C, 8'h20,
                               8'h28, 8'h2C, 8'h34, 8'h38, 8'h3C, 8'h18, 8'h35, 8'hFC};
    repeat (3) cycle(1, 0, 0, 8'h0, 32'h0, '0);          // R10 reset state
    rd(8'h00, '0); rd(8'h34, '0);                         // R10 state after reset
    wr(8'h00, 32'h0000_0008, '0);                         // R3 pin1 output
    wr(8'h1C, 32'h0000_0002, '0);                         // R4 set pin1
    wr(8'h28, 32'h0000_0002, '0);                         // R5 clear pin1
    wr(8'h20, 32'hFFFF_FFFF, '0);                         // R9 pins 32..53 high, rest ignored
    wr(8'h2C, 32'h0000_0008, '0);                         // R5 clear pin35
    wr(8'h0C, 32'h0002_8000, '0);                         // R2 pin35 alt1=101
    rd(8'h0C, '0);                                        // R1 readback
    wr(8'h14, 32'hFFFF_FFFF, '0);                         // R9 function word 5 high bits
    rd(8'h14, '0); rd(8'h1C, '0); rd(8'h2C, '0);          // R9, R8
    wr(8'h1C, 32'h0000_0002, '0);                         // R4 set pin1 again
    wr(8'h00, 32'h0000_0000, '0);                         // R6 pin1 to input, latch stays
    cycle(0, 0, 0, 8'h0, 32'h0, '0);                      // R6 hold
    wr(8'h34, 32'hFFFF_FFFF, '0); rd(8'h34, '0);          // R8 write to level ignored
    wr(8'h01, 32'hFFFF_FFFF, '0); rd(8'h00, '0);          // R8 misaligned write ignored
    pv = {22'h2AAAAA, 32'hDEADBEEF};
    for (int i = 0; i < 4; i++) rd(8'h34 + 8'(4*(i%2)), pv); // R7 synchronizer delay
    for (int i = 0; i < 6; i++) rd(8'h38, pv ^ NP'(i));   // R7, R9
    cycle(0, 1, 1, 8'h00, 32'h0000_0001, pv);             // R11 read before write
    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 15);
      if ($urandom_range(0, 3) == 0) pv = {$urandom(), $urandom()};
      cycle(0, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, addrs[k],
            ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom(), pv);
      if (i == 2000) cycle(1, 0, 0, 8'h0, 32'h0, pv);     // R10 reset mid-run
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule